// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. It receives the test clock, mode select and serial data input. It drives a serial data output together with a separate output-enable, which the pad uses to float the pin. A sixteen-state controller steps through capture, shift and update phases under control of the mode select line. An instruction register chooses which data register sits in the serial path. Three data registers are available: a one-bit pass-through stage, a 32-bit fixed identity code, and a 90-bit snapshot of the device I/O ring. The snapshot arrives as a plain parallel input vector.

There is no dedicated test-reset pin. An asynchronous power-on reset puts the port into its reset state with the output disabled. After that, five consecutive clocks with the mode select high return the controller to its reset state, whatever state it was in. Serial data is taken in on the rising clock edge. The output and its enable change only on the falling edge.

Top module: `scan_tap`

## Requirements
- R1: From any controller state, five consecutive rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset. In that state `tdo_oe` is low, and the active instruction becomes IDCODE.
- R2: While `pwr_rst_n` is low, the controller is held in Test-Logic-Reset and `tdo_oe` is 0. After release, the first data scan returns the identity code.
- R3: `tdi` is sampled only on the rising edge of `tck`. `tdo` and `tdo_oe` change only on the falling edge of `tck`, so their values just after a rising edge equal the values from before that edge.
- R4: `tdo_oe` is 1 during the half cycle that follows a falling edge on which the controller is in Shift-IR or Shift-DR, and 0 otherwise. In Shift-IR the instruction shift stage feeds `tdo`. In Shift-DR only the one data register selected by the active instruction feeds `tdo`.
- R5: The active instruction is 3 bits wide. It is IDCODE (3'b001) after power-up and after every pass through Test-Logic-Reset, and it changes in no other state apart from Update-IR.
- R6: In Capture-IR the 3-bit instruction shift stage loads 3'b001. Its two least significant bits are therefore binary 01. The stage shifts out LSB first.
- R7: During Shift-IR, `tdi` enters the MSB of the 3-bit stage and the LSB drives `tdo`. The stage contents become the active instruction only in Update-IR. After an N-bit scan, the last three bits shifted form the code, and the earliest of those three lands in bit 0.
- R8: With BYPASS (3'b111) active, the single bypass bit is cleared to 0 in Capture-DR. During Shift-DR it delays `tdi` by one clock.
- R9: With IDCODE (3'b001) active, Capture-DR loads the 32-bit parameter `ID_CODE`. Shift-DR shifts it out LSB first.
- R10: With SAMPLE (3'b010) active, Capture-DR loads the 90-bit `io_ring` into the boundary register. In Shift-DR, `tdi` enters bit 89 and bit 0 drives `tdo`, so the bits shifted in reappear on `tdo` after 90 clocks.
- R11: Every instruction code other than 3'b001 and 3'b010 selects the bypass bit, with the behaviour of R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| pwr_rst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| io_ring | input | BSR_W (90) | Parallel snapshot of the device I/O ring |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for the `tdo` pad; 0 means high impedance |

## Verification
The bench checks the falling-edge output timing. It samples `tdo` just after each rising edge while `tdi` is flipped at that moment. A design that launched on the rising edge, or that sampled `tdi` late, would show the new bit too early or shift in the wrong one. It also performs a five-clock reset from inside Shift-DR and from inside Shift-IR. A controller that missed a path to Test-Logic-Reset, or that kept a half-shifted instruction, would return the boundary data instead of the identity code. It further checks a 5-bit instruction scan that ends on a reserved code. A wrong stage length would misplace the code, and a decoder without a default would connect no register or the wrong one. Finally, a 100-bit boundary scan shows the `tdi` bits coming back out after exactly 90 clocks, which exposes a register with the wrong length or with the shift running the wrong way.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int unsigned IR_W = 3;

    typedef logic [IR_W-1:0] instr_t;

    localparam instr_t OP_IDCODE  = 3'b001;
    localparam instr_t OP_SAMPLE  = 3'b010;
    localparam instr_t OP_BYPASS  = 3'b111;
    localparam instr_t IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SHF_DR,
        ST_EX1_DR,
        ST_PAU_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SHF_IR,
        ST_EX1_IR,
        ST_PAU_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DSEL_BYPASS,
        DSEL_IDENT,
        DSEL_BOUNDARY
    } dsel_e;

    // Reserved codes fall back to the single-bit path.
    function automatic dsel_e decode_instr(instr_t op);
        dsel_e sel;
        case (op)
            OP_IDCODE: sel = DSEL_IDENT;
            OP_SAMPLE: sel = DSEL_BOUNDARY;
            default:   sel = DSEL_BYPASS;
        endcase
        return sel;
    endfunction

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        tap_state_e n;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.st = tap_next(r_q.st, tms);
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_RESET};
        else        r_q <= r_d;
    end

    assign state = r_q.st;

    // R1
    five_high_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (r_q.st == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tdi,
    input  tap_state_e state,
    output instr_t     instr,
    output logic       ser_out
);

    typedef struct packed {
        instr_t stage;
        instr_t active;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_RESET:  r_d.active = OP_IDCODE;
            ST_CAP_IR: r_d.stage  = IR_CAPTURE;
            ST_SHF_IR: r_d.stage  = {tdi, r_q.stage[IR_W-1:1]};
            ST_UPD_IR: r_d.active = r_q.stage;
            default:   r_d        = r_q;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{stage: IR_CAPTURE, active: OP_IDCODE};
        else        r_q <= r_d;
    end

    assign instr   = r_q.active;
    assign ser_out = r_q.stage[0];

    // R5
    instr_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(r_q.active));

    // R5
    reset_loads_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET) |=> (r_q.active == OP_IDCODE));

    // R6
    capture_pattern_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> (r_q.stage[1:0] == 2'b01));

    // R7
    update_takes_stage_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_UPD_IR) |=> (r_q.active == $past(r_q.stage)));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int unsigned        ID_W    = 32,
    parameter int unsigned        BSR_W   = 90,
    parameter logic [ID_W-1:0]    ID_CODE = 32'h4D1C_6A35
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tdi,
    input  tap_state_e       state,
    input  instr_t           instr,
    input  logic [BSR_W-1:0] io_ring,
    output logic             ser_out
);

    typedef struct packed {
        logic             byp;
        logic [ID_W-1:0]  ident;
        logic [BSR_W-1:0] bsr;
    } dr_regs_t;

    dr_regs_t r_d, r_q;
    dsel_e    sel;

    assign sel = decode_instr(instr);

    always_comb begin
        r_d = r_q;
        if (state == ST_CAP_DR) begin
            case (sel)
                DSEL_IDENT:    r_d.ident = ID_CODE;
                DSEL_BOUNDARY: r_d.bsr   = io_ring;
                default:       r_d.byp   = 1'b0;
            endcase
        end else if (state == ST_SHF_DR) begin
            case (sel)
                DSEL_IDENT:    r_d.ident = {tdi, r_q.ident[ID_W-1:1]};
                DSEL_BOUNDARY: r_d.bsr   = {tdi, r_q.bsr[BSR_W-1:1]};
                default:       r_d.byp   = tdi;
            endcase
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{byp: 1'b0, ident: ID_CODE, bsr: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        case (sel)
            DSEL_IDENT:    ser_out = r_q.ident[0];
            DSEL_BOUNDARY: ser_out = r_q.bsr[0];
            default:       ser_out = r_q.byp;
        endcase
    end

    // R8
    bypass_clear_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR && instr == OP_BYPASS) |=> (r_q.byp == 1'b0));

    // R11
    reserved_bypass_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR && instr != OP_IDCODE && instr != OP_SAMPLE)
        |=> (r_q.byp == 1'b0));

    // R9
    ident_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR && instr == OP_IDCODE) |=> (r_q.ident == ID_CODE));

    // R10
    ring_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR && instr == OP_SAMPLE) |=> (r_q.bsr == $past(io_ring)));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import tap_pkg::*;
#(
    parameter int unsigned     ID_W    = 32,
    parameter int unsigned     BSR_W   = 90,
    parameter logic [ID_W-1:0] ID_CODE = 32'h4D1C_6A35
) (
    input  logic             tck,
    input  logic             pwr_rst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BSR_W-1:0] io_ring,
    output logic             tdo,
    output logic             tdo_oe
);

    tap_state_e state;
    instr_t     instr;
    logic       ir_so;
    logic       dr_so;

    tap_fsm i_fsm (
        .tck   (tck),
        .rst_n (pwr_rst_n),
        .tms   (tms),
        .state (state)
    );

    tap_ir i_ir (
        .tck     (tck),
        .rst_n   (pwr_rst_n),
        .tdi     (tdi),
        .state   (state),
        .instr   (instr),
        .ser_out (ir_so)
    );

    tap_dr #(
        .ID_W    (ID_W),
        .BSR_W   (BSR_W),
        .ID_CODE (ID_CODE)
    ) i_dr (
        .tck     (tck),
        .rst_n   (pwr_rst_n),
        .tdi     (tdi),
        .state   (state),
        .instr   (instr),
        .io_ring (io_ring),
        .ser_out (dr_so)
    );

    typedef struct packed {
        logic dout;
        logic oe;
    } out_regs_t;

    out_regs_t o_d, o_q;

    always_comb begin
        o_d.oe   = (state == ST_SHF_IR) || (state == ST_SHF_DR);
        o_d.dout = (state == ST_SHF_IR) ? ir_so : dr_so;
    end

    always_ff @(negedge tck or negedge pwr_rst_n) begin
        if (!pwr_rst_n) o_q <= '{dout: 1'b0, oe: 1'b0};
        else            o_q <= o_d;
    end

    assign tdo    = o_q.dout;
    assign tdo_oe = o_q.oe;

    // R4
    enable_in_shift_chk: assert property (@(posedge tck) disable iff (!pwr_rst_n)
        tdo_oe == ((state == ST_SHF_IR) || (state == ST_SHF_DR)));

    // R1
    reset_state_quiet_chk: assert property (@(posedge tck) disable iff (!pwr_rst_n)
        (state == ST_RESET) |-> !tdo_oe);

endmodule

// File: tb/test_scan_tap.sv
module test_scan_tap;
    import tap_pkg::*;

    localparam logic [31:0] EXP_ID = 32'h4D1C_6A35;
    localparam logic [89:0] RING_A = 90'h2AA_5555_AAAA_5555_AAAA_5555;
    localparam logic [89:0] RING_B = 90'h1C3_0F0F_1234_5678_9ABC_DEF0;

    logic        tck = 1'b0;
    logic        pwr_rst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic [89:0] io_ring = '0;
    logic        tdo;
    logic        tdo_oe;

    logic        tdo_at_rise;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    scan_tap #(.ID_W(32), .BSR_W(90), .ID_CODE(EXP_ID)) i_scan_tap (
        .tck       (tck),
        .pwr_rst_n (pwr_rst_n),
        .tms       (tms),
        .tdi       (tdi),
        .io_ring   (io_ring),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe)
    );

    always #4 tck = ~tck;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive, clock once, flip tdi just after the rising edge (R3), settle past falling edge.
    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        #1;
        tdo_at_rise = tdo;
        tdi = ~d;
        @(negedge tck);
        #1;
    endtask

    task automatic to_shift_dr();
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic to_shift_ir();
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    // Starts in a shift state, leaves through Update to Run-Test/Idle.
    task automatic scan(input int n, input logic [127:0] din, output logic [127:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            logic prev;
            dout[i] = tdo;
            chk(tdo_oe === 1'b1, "R4 enable in shift", 128'(tdo_oe), 128'd1);
            prev = tdo;
            step(i == n - 1, din[i]);
            chk(tdo_at_rise === prev, "R3 tdo held at rising edge", 128'(tdo_at_rise),
                128'(prev));
        end
        chk(tdo_oe === 1'b0, "R4 enable off in exit", 128'(tdo_oe), 128'd0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic load_instr(input instr_t op);
        logic [127:0] dout;
        to_shift_ir();
        scan(3, 128'(op), dout);
    endtask

    task automatic t_power_up();
        logic [127:0] dout;
        chk(tdo_oe === 1'b0, "R2 output off at power-up", 128'(tdo_oe), 128'd0);
        step(1'b0, 1'b0);
        chk(tdo_oe === 1'b0, "R4 output off in idle", 128'(tdo_oe), 128'd0);
        to_shift_dr();
        scan(32, 128'hFFFF_0000, dout);
        chk(dout[31:0] === EXP_ID, "R2 R5 R9 identity after power-up", dout, 128'(EXP_ID));
    endtask

    task automatic t_ir_capture();
        logic [127:0] dout;
        to_shift_ir();
        scan(3, 128'(OP_SAMPLE), dout);
        chk(dout[1:0] === 2'b01, "R6 capture lsbs 01", dout, 128'd1);
        chk(dout[2] === 1'b0, "R6 capture msb", 128'(dout[2]), 128'd0);
    endtask

    task automatic t_sample();
        logic [127:0] dout;
        logic [127:0] din;
        din = 128'h0000_0000_0000_0000_0000_0000_0000_02D9;
        io_ring = RING_A;
        to_shift_dr();
        io_ring = '0;
        scan(100, din, dout);
        chk(dout[89:0] === RING_A, "R10 ring snapshot A", 128'(dout[89:0]), 128'(RING_A));
        chk(dout[99:90] === din[9:0], "R10 tdi reappears after 90", 128'(dout[99:90]),
            128'(din[9:0]));
        io_ring = RING_B;
        to_shift_dr();
        scan(90, '0, dout);
        chk(dout[89:0] === RING_B, "R10 ring snapshot B", 128'(dout[89:0]), 128'(RING_B));
    endtask

    task automatic t_bypass();
        logic [127:0] dout;
        load_instr(OP_BYPASS);
        to_shift_dr();
        scan(8, 128'hB6, dout);
        chk(dout[0] === 1'b0, "R8 bypass captures 0", 128'(dout[0]), 128'd0);
        chk(dout[7:1] === 7'h36, "R8 R4 one-clock delay", 128'(dout[7:1]), 128'h36);
    endtask

    task automatic t_reserved();
        logic [127:0] dout;
        to_shift_ir();
        scan(5, 128'b10011, dout);
        chk(dout[2:0] === 3'b001, "R6 capture before long scan", 128'(dout[2:0]), 128'd1);
        chk(dout[4:3] === 2'b11, "R7 3-bit stage length", 128'(dout[4:3]), 128'd3);
        to_shift_dr();
        scan(8, 128'h5A, dout);
        chk(dout[0] === 1'b0, "R11 reserved 100 captures 0", 128'(dout[0]), 128'd0);
        chk(dout[7:1] === 7'h5A, "R11 R7 reserved 100 is bypass", 128'(dout[7:1]), 128'h5A);
        load_instr(3'b000);
        to_shift_dr();
        scan(6, 128'h2D, dout);
        chk(dout[5:0] === 6'h1A, "R11 reserved 000 is bypass", 128'(dout[5:0]), 128'h1A);
    endtask

    task automatic t_tap_reset();
        logic [127:0] dout;
        load_instr(OP_SAMPLE);
        io_ring = RING_A;
        to_shift_dr();
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        chk(tdo_oe === 1'b0, "R1 output off after reset from Shift-DR", 128'(tdo_oe), 128'd0);
        step(1'b0, 1'b0);
        to_shift_dr();
        scan(32, '0, dout);
        chk(dout[31:0] === EXP_ID, "R1 R5 IDCODE after reset from Shift-DR", dout,
            128'(EXP_ID));
        load_instr(OP_BYPASS);
        to_shift_ir();
        for (int k = 0; k < 5; k++) step(1'b1, 1'b1);
        chk(tdo_oe === 1'b0, "R1 output off after reset from Shift-IR", 128'(tdo_oe), 128'd0);
        step(1'b0, 1'b0);
        to_shift_dr();
        scan(32, '0, dout);
        chk(dout[31:0] === EXP_ID, "R1 R5 IDCODE after reset from Shift-IR", dout,
            128'(EXP_ID));
    endtask

    initial begin
        #3;
        chk(tdo_oe === 1'b0, "R2 output off during power-on reset", 128'(tdo_oe), 128'd0);
        #17;
        @(negedge tck);
        #1;
        pwr_rst_n = 1'b1;
        t_power_up();
        t_ir_capture();
        t_sample();
        t_bypass();
        t_reserved();
        t_tap_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule